// File: doc/BRIEF.md
# Programmable Interval Trigger Timer

This block is a free-running interval timer. A 16-bit timeout value is loaded through a write port. Once started, the timer counts clock periods. Each time the count reaches the timeout, it issues a single-cycle event and the count wraps to zero. A busy output shows whether the timer is running. A select input decides whether the start-of-conversion trigger output carries the timer event or an external trigger.

Rewriting the timeout while the timer runs restarts the count from zero. This means a smaller new value can never leave the counter beyond the compare point, where it would have to roll over. A timeout of zero gives an event on every clock. In general the event period is timeout+1 clock cycles.

Top module: `itrig_timer`

## Requirements
- R1: While running, `evt` is high for exactly one cycle whenever the count equals the timeout. The count then returns to zero. With timeout T, the first event comes T cycles after the start edge, and later events follow every T+1 cycles.
- R2: A start pulse (start=1, stop=0) sets `busy` to 1 at the next clock edge and restarts the count from zero.
- R3: A stop pulse clears `busy` at the next clock edge. While `busy` is 0, `evt` stays 0. When start and stop are both high in the same cycle, stop wins.
- R4: With a timeout of zero and the timer running, `evt` is 1 on every cycle.
- R5: A timeout write while running stores the new value and clears the count at the same edge. The next event comes exactly new-timeout cycles after that edge.
- R6: A timeout write while stopped changes only the stored value. `busy` stays 0, no event occurs, and the next start uses the new value.
- R7: After reset, `busy` is 0, `evt` is 0 and the stored timeout is 0.
- R8: `soc_trig` follows `ext_trig` when `trig_sel`=1 and follows `evt` when `trig_sel`=0. It has no register stage by default.
- R9: A start pulse while already running restarts the count from zero, so the next event comes T cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the timeout counts its periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Timeout write strobe |
| wr_data | input | 16 | New timeout value |
| start | input | 1 | Start command pulse |
| stop | input | 1 | Stop command pulse |
| trig_sel | input | 1 | Trigger source select: 0 timer event, 1 external |
| ext_trig | input | 1 | External trigger input |
| busy | output | 1 | 1 while running, 0 while stopped |
| evt | output | 1 | Single-cycle timer event |
| soc_trig | output | 1 | Selected start-of-conversion trigger |

## Verification
A corrupted count shows at `evt` as an event that comes early, late or never. This is seen within one timeout period, or at once after a restart or a rewrite. A lost clear after a running rewrite shows as a missing event at the expected offset. With a shrinking value it shows as a wrap through the full 16-bit range. A wrong run state shows on `busy` at the next edge, and as events that appear while stopped.

// File: rtl/itrig_pkg.sv
package itrig_pkg;
   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_START = 2'd1,
      CMD_STOP  = 2'd2
   } itrig_cmd_e;
endpackage

// File: rtl/itrig_ctrl.sv
module itrig_ctrl
   import itrig_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       stop,
   output itrig_cmd_e cmd,
   output logic       busy
);
   // stop has priority over start
   always_comb begin
      if (stop)       cmd = CMD_STOP;
      else if (start) cmd = CMD_START;
      else            cmd = CMD_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                busy <= 1'b0;
      else if (cmd == CMD_STOP)  busy <= 1'b0;
      else if (cmd == CMD_START) busy <= 1'b1;
   end
endmodule

// File: rtl/itrig_counter.sv
module itrig_counter
   import itrig_pkg::*;
#(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  itrig_cmd_e    cmd,
   input  logic          busy,
   input  logic          wr_en,
   input  logic [TW-1:0] wr_data,
   output logic [TW-1:0] cnt,
   output logic [TW-1:0] tmo,
   output logic          evt
);
   localparam logic [TW-1:0] ONE = TW'(1);

   logic hit;
   assign hit = (cnt == tmo);
   assign evt = busy && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tmo <= '0;
      else if (wr_en) tmo <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (cmd == CMD_STOP)  cnt <= cnt;
      else if (cmd == CMD_START) cnt <= '0;
      else if (busy) begin
         if (wr_en || hit)       cnt <= '0;
         else                    cnt <= cnt + ONE;
      end
   end
endmodule

// File: rtl/itrig_srcsel.sv
module itrig_srcsel #(
   parameter bit SRC_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic timer_evt,
   input  logic ext_trig,
   output logic trig
);
   logic pick;
   assign pick = sel ? ext_trig : timer_evt;

   generate
      if (SRC_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) trig <= 1'b0;
            else        trig <= pick;
         end
      end else begin : g_comb
         assign trig = pick;
      end
   endgenerate
endmodule

// File: rtl/itrig_timer.sv
module itrig_timer
   import itrig_pkg::*;
#(
   parameter int TW      = 16,
   parameter bit SRC_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [TW-1:0] wr_data,
   input  logic          start,
   input  logic          stop,
   input  logic          trig_sel,
   input  logic          ext_trig,
   output logic          busy,
   output logic          evt,
   output logic          soc_trig
);
   generate
      if (TW < 2 || TW > 32) begin : g_bad_tw
         $error("itrig_timer: TW must lie in 2..32");
      end
   endgenerate

   itrig_cmd_e    cmd;
   logic [TW-1:0] cnt;
   logic [TW-1:0] tmo;

   itrig_ctrl u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .stop  (stop),
      .cmd   (cmd),
      .busy  (busy)
   );

   itrig_counter #(.TW(TW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .busy    (busy),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .cnt     (cnt),
      .tmo     (tmo),
      .evt     (evt)
   );

   itrig_srcsel #(.SRC_REG(SRC_REG)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (trig_sel),
      .timer_evt (evt),
      .ext_trig  (ext_trig),
      .trig      (soc_trig)
   );
endmodule

// File: rtl/itrig_timer_chk.sv
module itrig_timer_chk #(
   parameter int TW      = 16,
   parameter bit SRC_REG = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          start,
   input logic          stop,
   input logic          trig_sel,
   input logic          ext_trig,
   input logic          busy,
   input logic          evt,
   input logic          soc_trig,
   input logic [TW-1:0] cnt,
   input logic [TW-1:0] tmo
);
   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stop) |=> (busy && cnt == '0));

   p_stop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !busy);

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !evt);

   p_zero_every_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tmo == '0) |-> evt);

   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !stop && !start) |=> (cnt == '0));

   p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && !stop) |=> (cnt == '0));

   p_idle_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(cnt));

   p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !wr_en && !start) |=> (cnt <= tmo || !busy));

   generate
      if (SRC_REG) begin : g_reg_chk
         p_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (soc_trig == $past(trig_sel ? ext_trig : evt)));
      end else begin : g_comb_chk
         p_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
            soc_trig == (trig_sel ? ext_trig : evt));
      end
   endgenerate
endmodule

bind itrig_timer itrig_timer_chk #(.TW(TW), .SRC_REG(SRC_REG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .start    (start),
   .stop     (stop),
   .trig_sel (trig_sel),
   .ext_trig (ext_trig),
   .busy     (busy),
   .evt      (evt),
   .soc_trig (soc_trig),
   .cnt      (cnt),
   .tmo      (tmo)
);

// File: tb/itrig_timer_test.sv
`timescale 1ns/1ps
module itrig_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        start = 1'b0;
   logic        stop = 1'b0;
   logic        trig_sel = 1'b0;
   logic        ext_trig = 1'b0;
   logic        busy, evt, soc_trig;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   itrig_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .start(start), .stop(stop), .trig_sel(trig_sel), .ext_trig(ext_trig),
      .busy(busy), .evt(evt), .soc_trig(soc_trig)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic write_tmo(input logic [15:0] v);
      wr_en = 1'b1; wr_data = v;
      step();
      wr_en = 1'b0;
   endtask

   task automatic do_start();
      start = 1'b1;
      step();
      start = 1'b0;
   endtask

   task automatic do_stop();
      stop = 1'b1;
      step();
      stop = 1'b0;
   endtask

   // observe n cycles after a start/clear edge, expect evt at i%(T+1)==T
   task automatic watch(input int t, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         chk(evt, (i % (t + 1)) == t, $sformatf("%s evt cycle %0d T=%0d", tag, i, t));
         step();
      end
   endtask

   task automatic t_reset();
      chk(busy, 0, "R7 busy after reset");
      chk(evt, 0, "R7 evt after reset");
      chk(soc_trig, 0, "R7 soc_trig after reset");
   endtask

   task automatic t_idle_write();
      write_tmo(16'd3);
      for (int i = 0; i < 5; i++) begin
         chk(busy, 0, "R6 busy after idle write");
         chk(evt, 0, "R6 no evt after idle write");
         step();
      end
   endtask

   task automatic t_period();
      do_start();
      chk(busy, 1, "R2 busy after start");
      watch(3, 12, "R1");
      do_stop();
   endtask

   task automatic t_zero();
      write_tmo(16'd0);
      chk(busy, 0, "R6 still idle after zero write");
      do_start();
      for (int i = 0; i < 5; i++) begin
         chk(evt, 1, "R4 evt every cycle");
         step();
      end
      do_stop();
   endtask

   task automatic t_rewrite();
      write_tmo(16'd5);
      do_start();
      step(); step(); step();          // count now 3
      chk(evt, 0, "R5 before rewrite");
      write_tmo(16'd2);                  // count cleared at this edge
      chk(busy, 1, "R5 busy kept");
      watch(2, 7, "R5");
      do_stop();
   endtask

   task automatic t_stop();
      write_tmo(16'd1);
      do_start();
      step();
      do_stop();
      for (int i = 0; i < 8; i++) begin
         chk(evt, 0, "R3 no evt while stopped");
         step();
      end
      chk(busy, 0, "R3 busy cleared");
      start = 1'b1; stop = 1'b1;
      step();
      start = 1'b0; stop = 1'b0;
      chk(busy, 0, "R3 stop wins over start");
      chk(evt, 0, "R3 no evt after tie");
   endtask

   task automatic t_restart();
      write_tmo(16'd4);
      do_start();
      step(); step();                  // count 2
      do_start();                      // restart
      chk(busy, 1, "R9 busy after restart");
      watch(4, 10, "R9");
      do_stop();
   endtask

   task automatic t_sel();
      write_tmo(16'd0);
      do_start();
      trig_sel = 1'b1; ext_trig = 1'b0;
      #0.5;
      chk(soc_trig, 0, "R8 ext low selected");
      ext_trig = 1'b1;
      #0.5;
      chk(soc_trig, 1, "R8 ext high selected");
      trig_sel = 1'b0; ext_trig = 1'b0;
      #0.5;
      chk(soc_trig, 1, "R8 timer evt selected");
      do_stop();
      chk(soc_trig, 0, "R8 timer idle selected");
   endtask

   initial begin
      step(); step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_idle_write();
      t_period();
      t_zero();
      t_rewrite();
      t_stop();
      t_restart();
      t_sel();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule